// File: doc/BRIEF.md
# DDR Command Bus Monitor with Bank Tracking

This block watches the command pins of a DDR SDRAM bus without driving them. At every rising clock edge it takes the earlier and the present clock-enable level, the chip-select, row-strobe, column-strobe and write-enable lines, the two bank-select bits and address bit 10. From these it names the command on the bus, including clock-enable transitions into and out of power-down and self-refresh. It also follows which of the four banks hold an open row.

Nanosecond timing limits are turned into whole clock cycles by parameters and checked with per-bank and bus-wide age counters. The limits are row-to-column delay, precharge recovery, activate spacing between banks, minimum row-open time, activate-to-activate on one bank and the settle time after a mode-register write. The block also checks the ordering rules: a mode write or refresh needs all banks idle, a column access needs an open row, and an activate needs a closed one. Each broken rule sets a sticky bit. A saturating counter tallies the cycles in which at least one rule broke. A synchronous clear input empties both.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: During synchronous active-low reset the outputs go to cmd_code 0, bank_open 0, viol 0 and err_cnt 0.
- R2: With both clock-enable samples high, cmd_code one cycle later is: chip-select high 1 (deselect). With chip-select low, the {ras_n,cas_n,we_n} lines decode as follows: 111 gives 0 (no-op), 000 gives 2 (mode write), 001 gives 3 (refresh), 011 gives 4 (activate), 110 gives 7 (burst stop). 101 is a read: 5, or 13 when a10 is high. 100 is a write: 6, or 14 when a10 is high. 010 is a precharge: 8, or 15 when a10 is high.
- R3: Clock-enable high then low gives code 10 when chip-select is low with lines 001, and code 9 otherwise. Low then high gives 11. Low then low gives 12.
- R4: An activate opens bank ba, where ba value n selects bank n and bank_open[n]. A precharge with a10 low closes bank ba. A precharge with a10 high closes every bank and ignores ba. A read or write with a10 high closes its bank.
- R5: A read or write to an open bank fewer than T_RCD cycles (default 3) after that bank's activate sets viol[2].
- R6: An activate fewer than T_RP cycles (default 3) after the same bank was closed sets viol[3].
- R7: An activate fewer than T_RRD cycles (default 2) after an activate to a different bank sets viol[4].
- R8: A precharge (single or all) that closes an open bank fewer than T_RAS cycles (default 6) after its activate sets viol[5].
- R9: An activate fewer than T_RC cycles (default 9) after the previous activate of the same bank sets viol[6].
- R10: Any command other than no-op, deselect or clock-held-low that comes fewer than T_MRD cycles (default 2) after a mode write sets viol[0].
- R11: A mode write, refresh or self-refresh entry while any bank is open sets viol[1].
- R12: A read or write to a closed bank, or an activate to an open bank, sets viol[7].
- R13: viol bits stay set until clr is high at an edge, which zeroes viol and err_cnt. Otherwise err_cnt rises by one in every cycle with any violation and holds at its all-ones maximum (255 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of violation bits and counter |
| cke_prev | input | 1 | Clock-enable level at the previous edge |
| cke_cur | input | 1 | Clock-enable level at this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| a10 | input | 1 | Address bit 10 (auto-precharge / all-banks) |
| cmd_code | output | 4 | Decoded command of the previous cycle |
| bank_open | output | 4 | One open-row flag per bank |
| viol | output | 8 | Sticky violation bits |
| err_cnt | output | 8 | Saturating count of violating cycles |

## Verification
A wrong open flag shows on bank_open in the cycle after the command that set it. It also shows a little later as a false or missing viol[7] on the next access to that bank. A per-bank or bus-wide age counter that is off by one changes which spacing is accepted. Commands are therefore placed exactly at the limit and one cycle below it, so that the bit appears or stays clear one edge later. A counter that wraps instead of saturating appears only after more than 255 violating cycles, so one scenario drives that many.

// File: rtl/ddr_mon_pkg.sv
`timescale 1ns/1ps
// Shared command codes, violation bit indices and the nanosecond-to-cycle helper.
package ddr_mon_pkg;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_DESEL = 4'd1,
        CMD_MRS   = 4'd2,
        CMD_REF   = 4'd3,
        CMD_ACT   = 4'd4,
        CMD_RD    = 4'd5,
        CMD_WR    = 4'd6,
        CMD_BST   = 4'd7,
        CMD_PRE   = 4'd8,
        CMD_PDE   = 4'd9,
        CMD_SRE   = 4'd10,
        CMD_CKX   = 4'd11,
        CMD_CKL   = 4'd12,
        CMD_RDA   = 4'd13,
        CMD_WRA   = 4'd14,
        CMD_PREA  = 4'd15
    } cmd_e;

    localparam int V_MRD   = 0;
    localparam int V_OPEN  = 1;
    localparam int V_RCD   = 2;
    localparam int V_RP    = 3;
    localparam int V_RRD   = 4;
    localparam int V_RAS   = 5;
    localparam int V_RC    = 6;
    localparam int V_STATE = 7;
    localparam int V_NUM   = 8;

    // Round a picosecond limit up to whole clock cycles.
    function automatic int ps2cyc(input int lim_ps, input int clk_ps);
        return (lim_ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
`timescale 1ns/1ps
// Command decoder: turns one sample of the control pins into a command code.
// Assumes cke_prev/cke_cur are the clock-enable levels at the last and present edge.
// Purely combinational; the top module registers the result.
module ddr_cmd_decode
    import ddr_mon_pkg::*;
(
    input  logic cke_prev,
    input  logic cke_cur,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    output cmd_e cmd
);

    logic refresh_pat;
    assign refresh_pat = !cs_n && !ras_n && !cas_n && we_n;

    // Map clock-enable history first, then the strobe pattern.
    always_comb begin
        if (!cke_prev && !cke_cur) begin
            cmd = CMD_CKL;
        end else if (!cke_prev) begin
            cmd = CMD_CKX;
        end else if (!cke_cur) begin
            cmd = refresh_pat ? CMD_SRE : CMD_PDE;
        end else if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = CMD_REF;
                3'b010:  cmd = a10 ? CMD_PREA : CMD_PRE;
                3'b011:  cmd = CMD_ACT;
                3'b100:  cmd = a10 ? CMD_WRA : CMD_WR;
                3'b101:  cmd = a10 ? CMD_RDA : CMD_RD;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddr_bank_tracker.sv
`timescale 1ns/1ps
// Bank tracker: holds the open/closed state of every bank and the cycle ages
// since each bank's last activate and last close, plus bus-wide ages since the
// last activate and the last mode write. Reports this cycle's rule breaks.
// Assumes cmd is the decoded command of the present edge.
module ddr_bank_tracker
    import ddr_mon_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RRD = 2,
    parameter int T_RAS = 6,
    parameter int T_RC  = 9,
    parameter int T_MRD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [BA_W-1:0]   ba,
    output logic [(1<<BA_W)-1:0] open_o,
    output logic [V_NUM-1:0]  hit_o
);

    localparam int NB      = 1 << BA_W;
    localparam int ACT_LIM = (T_RC > T_RAS) ? ((T_RC > T_RCD) ? T_RC : T_RCD)
                                            : ((T_RAS > T_RCD) ? T_RAS : T_RCD);
    localparam int BUS_LIM = (T_RRD > T_MRD) ? T_RRD : T_MRD;
    localparam int MAXL    = (ACT_LIM > T_RP) ? ((ACT_LIM > BUS_LIM) ? ACT_LIM : BUS_LIM)
                                              : ((T_RP > BUS_LIM) ? T_RP : BUS_LIM);
    localparam int AW      = $clog2(MAXL + 1);

    localparam logic [AW-1:0] L_ACT = AW'(ACT_LIM);
    localparam logic [AW-1:0] L_RCD = AW'(T_RCD);
    localparam logic [AW-1:0] L_RP  = AW'(T_RP);
    localparam logic [AW-1:0] L_RRD = AW'(T_RRD);
    localparam logic [AW-1:0] L_RAS = AW'(T_RAS);
    localparam logic [AW-1:0] L_RC  = AW'(T_RC);
    localparam logic [AW-1:0] L_MRD = AW'(T_MRD);

    logic is_act, is_acc, is_ap, is_pre, is_prea, is_idle_need, is_real;
    assign is_act       = (cmd == CMD_ACT);
    assign is_acc       = (cmd == CMD_RD) || (cmd == CMD_WR) || (cmd == CMD_RDA) || (cmd == CMD_WRA);
    assign is_ap        = (cmd == CMD_RDA) || (cmd == CMD_WRA);
    assign is_pre       = (cmd == CMD_PRE);
    assign is_prea      = (cmd == CMD_PREA);
    assign is_idle_need = (cmd == CMD_MRS) || (cmd == CMD_REF) || (cmd == CMD_SRE);
    assign is_real      = (cmd != CMD_NOP) && (cmd != CMD_DESEL) && (cmd != CMD_CKL);

    logic [NB-1:0] open_q;
    logic [NB-1:0] act_sel, acc_sel, pre_sel, close_sel;
    logic [NB-1:0] rcd_b, rp_b, ras_b, rc_b, st_b;

    genvar b;
    generate
        for (b = 0; b < NB; b++) begin : g_bank
            logic [AW-1:0] act_age;
            logic [AW-1:0] pre_age;

            assign act_sel[b]   = is_act && (ba == BA_W'(b));
            assign acc_sel[b]   = is_acc && (ba == BA_W'(b));
            assign pre_sel[b]   = (is_pre && (ba == BA_W'(b))) || is_prea;
            assign close_sel[b] = open_q[b] && (pre_sel[b] || (is_ap && (ba == BA_W'(b))));

            assign rcd_b[b] = acc_sel[b] && open_q[b] && (act_age < L_RCD);
            assign rp_b[b]  = act_sel[b] && (pre_age < L_RP);
            assign ras_b[b] = pre_sel[b] && open_q[b] && (act_age < L_RAS);
            assign rc_b[b]  = act_sel[b] && (act_age < L_RC);
            assign st_b[b]  = (acc_sel[b] && !open_q[b]) || (act_sel[b] && open_q[b]);

            // Update this bank's open flag and its two saturating ages.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    open_q[b] <= 1'b0;
                    act_age   <= L_ACT;
                    pre_age   <= L_RP;
                end else begin
                    if (act_sel[b]) begin
                        open_q[b] <= 1'b1;
                        act_age   <= AW'(1);
                    end else begin
                        if (close_sel[b]) open_q[b] <= 1'b0;
                        if (act_age < L_ACT) act_age <= act_age + AW'(1);
                    end
                    if (close_sel[b])       pre_age <= AW'(1);
                    else if (pre_age < L_RP) pre_age <= pre_age + AW'(1);
                end
            end

            // R4
            act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
                act_sel[b] |=> open_q[b]);
        end
    endgenerate

    logic [AW-1:0]   rrd_age;
    logic [AW-1:0]   mrd_age;
    logic [BA_W-1:0] last_ba;

    // Track bus-wide ages since the last activate and the last mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_age <= L_RRD;
            mrd_age <= L_MRD;
            last_ba <= '0;
        end else begin
            if (is_act) begin
                rrd_age <= AW'(1);
                last_ba <= ba;
            end else if (rrd_age < L_RRD) begin
                rrd_age <= rrd_age + AW'(1);
            end
            if (cmd == CMD_MRS)       mrd_age <= AW'(1);
            else if (mrd_age < L_MRD) mrd_age <= mrd_age + AW'(1);
        end
    end

    // Gather this cycle's rule breaks into one vector.
    always_comb begin
        hit_o          = '0;
        hit_o[V_MRD]   = is_real && (mrd_age < L_MRD);
        hit_o[V_OPEN]  = is_idle_need && (|open_q);
        hit_o[V_RCD]   = |rcd_b;
        hit_o[V_RP]    = |rp_b;
        hit_o[V_RRD]   = is_act && (rrd_age < L_RRD) && (last_ba != ba);
        hit_o[V_RAS]   = |ras_b;
        hit_o[V_RC]    = |rc_b;
        hit_o[V_STATE] = |st_b;
    end

    assign open_o = open_q;

    // R4
    prea_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_prea |=> (open_q == '0));

endmodule

// File: rtl/ddr_viol_log.sv
`timescale 1ns/1ps
// Violation log: sticky OR of rule-break bits and a saturating count of
// cycles with any break. Assumes clr has priority over new breaks.
module ddr_viol_log #(
    parameter int NV = 8,
    parameter int EW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [NV-1:0] hit,
    output logic [NV-1:0] viol_o,
    output logic [EW-1:0] err_o
);

    localparam logic [EW-1:0] ERR_MAX = {EW{1'b1}};

    // Accumulate breaks and count violating cycles until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_o <= '0;
            err_o  <= '0;
        end else if (clr) begin
            viol_o <= '0;
            err_o  <= '0;
        end else begin
            viol_o <= viol_o | hit;
            if ((|hit) && (err_o != ERR_MAX)) err_o <= err_o + EW'(1);
        end
    end

    // R13
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (viol_o == '0) && (err_o == '0));

    // R13
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((viol_o & $past(viol_o)) == $past(viol_o)));

    // R13
    err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && err_o == ERR_MAX) |=> (err_o == ERR_MAX));

endmodule

// File: rtl/ddr_cmd_monitor.sv
`timescale 1ns/1ps
// DDR command bus monitor: decodes each sampled command, tracks open banks,
// and logs timing/ordering rule breaks. Timing limits are given in ps and
// rounded up to cycles of CLK_PS. Assumes synchronous active-low reset.
module ddr_cmd_monitor
    import ddr_mon_pkg::*;
#(
    parameter int BA_W     = 2,
    parameter int ERR_W    = 8,
    parameter int CLK_PS   = 7500,
    parameter int T_RCD_PS = 20000,
    parameter int T_RP_PS  = 20000,
    parameter int T_RRD_PS = 15000,
    parameter int T_RAS_PS = 45000,
    parameter int T_RC_PS  = 65000,
    parameter int T_MRD_CY = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   cke_prev,
    input  logic                   cke_cur,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        ba,
    input  logic                   a10,
    output logic [3:0]             cmd_code,
    output logic [(1<<BA_W)-1:0]   bank_open,
    output logic [V_NUM-1:0]       viol,
    output logic [ERR_W-1:0]       err_cnt
);

    localparam int C_RCD = ps2cyc(T_RCD_PS, CLK_PS);
    localparam int C_RP  = ps2cyc(T_RP_PS,  CLK_PS);
    localparam int C_RRD = ps2cyc(T_RRD_PS, CLK_PS);
    localparam int C_RAS = ps2cyc(T_RAS_PS, CLK_PS);
    localparam int C_RC  = ps2cyc(T_RC_PS,  CLK_PS);

    cmd_e             cur_cmd;
    logic [V_NUM-1:0] hit;

    ddr_cmd_decode u_dec (
        .cke_prev (cke_prev),
        .cke_cur  (cke_cur),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .a10      (a10),
        .cmd      (cur_cmd)
    );

    ddr_bank_tracker #(
        .BA_W  (BA_W),
        .T_RCD (C_RCD),
        .T_RP  (C_RP),
        .T_RRD (C_RRD),
        .T_RAS (C_RAS),
        .T_RC  (C_RC),
        .T_MRD (T_MRD_CY)
    ) u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cur_cmd),
        .ba     (ba),
        .open_o (bank_open),
        .hit_o  (hit)
    );

    ddr_viol_log #(
        .NV (V_NUM),
        .EW (ERR_W)
    ) u_log (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .hit    (hit),
        .viol_o (viol),
        .err_o  (err_cnt)
    );

    // Register the decoded command for the output.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_code <= CMD_NOP;
        else        cmd_code <= cur_cmd;
    end

    // R2
    desel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_prev && cke_cur && cs_n) |=> (cmd_code == 4'(CMD_DESEL)));

    // R12
    closed_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !bank_open[ba] && ((cur_cmd == CMD_RD) || (cur_cmd == CMD_WR) ||
         (cur_cmd == CMD_RDA) || (cur_cmd == CMD_WRA))) |=> viol[V_STATE]);

endmodule

// File: tb/tb_ddr_cmd_monitor.sv
`timescale 1ns/1ps
module tb_ddr_cmd_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       cke_prev = 1'b1, cke_cur = 1'b1;
    logic       cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'd0;
    logic       a10 = 1'b0;
    logic [3:0] cmd_code;
    logic [3:0] bank_open;
    logic [7:0] viol;
    logic [7:0] err_cnt;

    int checks = 0;
    int errors = 0;

    localparam logic [2:0] P_MRS = 3'b000, P_REF = 3'b001, P_PRE = 3'b010, P_ACT = 3'b011,
                           P_WR  = 3'b100, P_RD  = 3'b101, P_BST = 3'b110, P_NOP = 3'b111;

    always #4 clk = ~clk;

    ddr_cmd_monitor dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cke_prev(cke_prev), .cke_cur(cke_cur),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
        .cmd_code(cmd_code), .bank_open(bank_open), .viol(viol), .err_cnt(err_cnt)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic bus(input logic kp, input logic kc, input logic csn,
                       input logic [2:0] pat, input logic [1:0] b, input logic a, input logic c);
        @(negedge clk);
        cke_prev = kp; cke_cur = kc; cs_n = csn;
        {ras_n, cas_n, we_n} = pat; ba = b; a10 = a; clr = c;
        @(posedge clk);
        #1;
    endtask

    task automatic cyc(input logic [2:0] pat, input logic [1:0] b, input logic a);
        bus(1'b1, 1'b1, 1'b0, pat, b, a, 1'b0);
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) cyc(P_NOP, 2'd0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; clr = 1'b0; cke_prev = 1'b1; cke_cur = 1'b1; cs_n = 1'b0;
        {ras_n, cas_n, we_n} = P_NOP; ba = 2'd0; a10 = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 cmd", 16'(cmd_code), 16'd0);
        check("R1 open", 16'(bank_open), 16'd0);
        check("R1 viol", 16'(viol), 16'd0);
        check("R1 err", 16'(err_cnt), 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_decode();
        do_reset();
        cyc(P_MRS, 2'd0, 1'b0); check("R2 mrs", 16'(cmd_code), 16'd2);
        nop(1);                 check("R2 nop", 16'(cmd_code), 16'd0);
        cyc(P_REF, 2'd0, 1'b0); check("R2 ref", 16'(cmd_code), 16'd3);
        cyc(P_ACT, 2'd1, 1'b0); check("R2 act", 16'(cmd_code), 16'd4);
        cyc(P_RD,  2'd1, 1'b0); check("R2 rd", 16'(cmd_code), 16'd5);
        cyc(P_WR,  2'd1, 1'b0); check("R2 wr", 16'(cmd_code), 16'd6);
        cyc(P_BST, 2'd0, 1'b0); check("R2 bst", 16'(cmd_code), 16'd7);
        cyc(P_PRE, 2'd1, 1'b0); check("R2 pre", 16'(cmd_code), 16'd8);
        cyc(P_RD,  2'd1, 1'b1); check("R2 rda", 16'(cmd_code), 16'd13);
        cyc(P_WR,  2'd1, 1'b1); check("R2 wra", 16'(cmd_code), 16'd14);
        cyc(P_PRE, 2'd2, 1'b1); check("R2 prea", 16'(cmd_code), 16'd15);
        bus(1'b1, 1'b1, 1'b1, P_MRS, 2'd0, 1'b0, 1'b0); check("R2 desel", 16'(cmd_code), 16'd1);
    endtask

    task automatic t_cke();
        do_reset();
        bus(1'b1, 1'b0, 1'b1, P_NOP, 2'd0, 1'b0, 1'b0); check("R3 pd entry", 16'(cmd_code), 16'd9);
        bus(1'b0, 1'b0, 1'b1, P_NOP, 2'd0, 1'b0, 1'b0); check("R3 held low", 16'(cmd_code), 16'd12);
        bus(1'b0, 1'b1, 1'b1, P_NOP, 2'd0, 1'b0, 1'b0); check("R3 exit", 16'(cmd_code), 16'd11);
        bus(1'b1, 1'b0, 1'b0, P_REF, 2'd0, 1'b0, 1'b0); check("R3 sr entry", 16'(cmd_code), 16'd10);
        bus(1'b0, 1'b1, 1'b1, P_NOP, 2'd0, 1'b0, 1'b0);
        check("R3 no viol", 16'(viol), 16'd0);
    endtask

    task automatic t_legal();
        do_reset();
        cyc(P_ACT, 2'd1, 1'b0); check("R4 act opens", 16'(bank_open), 16'b0010);
        nop(2);
        cyc(P_RD, 2'd1, 1'b0);      // age 3: legal (R5 boundary)
        nop(2);
        cyc(P_PRE, 2'd1, 1'b0);     // age 6: legal (R8 boundary)
        check("R4 pre closes", 16'(bank_open), 16'b0000);
        nop(2);
        cyc(P_ACT, 2'd1, 1'b0);     // close age 3, act age 9: legal (R6/R9 boundary)
        cyc(P_ACT, 2'd3, 1'b1);     // a10 ignored on activate, follows at 1 -> RRD
        check("R7 rrd", 16'(viol), 16'h10);
        check("R5 R6 R9 legal spacing clean", 16'(viol & 8'h4C), 16'd0);
        check("R4 two open", 16'(bank_open), 16'b1010);
        nop(8);
        cyc(P_PRE, 2'd0, 1'b1);
        check("R4 prea closes all", 16'(bank_open), 16'd0);
    endtask

    task automatic t_rcd();
        do_reset();
        cyc(P_ACT, 2'd0, 1'b0); nop(1);
        cyc(P_WR, 2'd0, 1'b0);
        check("R5 rcd", 16'(viol), 16'h04);
        check("R13 err one", 16'(err_cnt), 16'd1);
    endtask

    task automatic t_rp();
        do_reset();
        cyc(P_ACT, 2'd2, 1'b0); nop(6);
        cyc(P_PRE, 2'd2, 1'b0); nop(1);
        cyc(P_ACT, 2'd2, 1'b0);
        check("R6 rp", 16'(viol), 16'h08);
    endtask

    task automatic t_ras();
        do_reset();
        cyc(P_ACT, 2'd3, 1'b0); nop(4);
        cyc(P_PRE, 2'd3, 1'b0);
        check("R8 ras single", 16'(viol), 16'h20);
        do_reset();
        cyc(P_ACT, 2'd0, 1'b0); nop(2);
        cyc(P_PRE, 2'd2, 1'b1);
        check("R8 ras all", 16'(viol), 16'h20);
        check("R4 closed after prea", 16'(bank_open), 16'd0);
    endtask

    task automatic t_rc();
        do_reset();
        cyc(P_ACT, 2'd1, 1'b0); nop(2);
        cyc(P_RD, 2'd1, 1'b1);
        check("R4 auto precharge closes", 16'(bank_open), 16'd0);
        nop(2);
        cyc(P_ACT, 2'd1, 1'b0);
        check("R9 rc", 16'(viol), 16'h40);
    endtask

    task automatic t_state();
        do_reset();
        cyc(P_RD, 2'd2, 1'b0);
        check("R12 read closed", 16'(viol), 16'h80);
        do_reset();
        cyc(P_ACT, 2'd0, 1'b0); nop(8);
        cyc(P_ACT, 2'd0, 1'b0);
        check("R12 act open", 16'(viol), 16'h80);
    endtask

    task automatic t_mrd();
        do_reset();
        cyc(P_MRS, 2'd0, 1'b0);
        cyc(P_ACT, 2'd0, 1'b0);
        check("R10 mrd early", 16'(viol), 16'h01);
        do_reset();
        cyc(P_MRS, 2'd0, 1'b0); nop(1);
        cyc(P_ACT, 2'd0, 1'b0);
        check("R10 mrd at limit", 16'(viol), 16'h00);
    endtask

    task automatic t_open();
        do_reset();
        cyc(P_ACT, 2'd0, 1'b0); nop(2);
        cyc(P_REF, 2'd0, 1'b0);
        check("R11 refresh open", 16'(viol), 16'h02);
        do_reset();
        cyc(P_ACT, 2'd3, 1'b0); nop(2);
        cyc(P_MRS, 2'd0, 1'b0);
        check("R11 mode open", 16'(viol), 16'h02);
    endtask

    task automatic t_sticky();
        do_reset();
        cyc(P_RD, 2'd1, 1'b0); nop(3);
        check("R13 sticky", 16'(viol), 16'h80);
        bus(1'b1, 1'b1, 1'b0, P_NOP, 2'd0, 1'b0, 1'b1);
        check("R13 clear viol", 16'(viol), 16'd0);
        check("R13 clear err", 16'(err_cnt), 16'd0);
        for (int i = 0; i < 260; i++) cyc(P_RD, 2'd1, 1'b0);
        check("R13 saturate", 16'(err_cnt), 16'd255);
        check("R13 bits", 16'(viol), 16'h80);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_decode();
        t_cke();
        t_legal();
        t_rcd();
        t_rp();
        t_ras();
        t_rc();
        t_state();
        t_mrd();
        t_open();
        t_sticky();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule